// File: doc/BRIEF.md
# Limit-Register Counter Timer Unit

This block is a bank of counter/timers sitting on a simple word-addressed register bus. It holds one system-wide timer and a parameterised number of per-processor timers. Every timer has a count register, a limit register and a second view of the limit register. On each cycle in which the `tick` input is high, a timer's count advances. When the count has reached the programmed limit, the count reloads to 1 and the timer's interrupt line rises. The interrupt is level-sensitive and stays high until software acknowledges it.

The acknowledge happens as a side effect of a bus read of the limit register. Software that only wants to look at or retune the limit goes through the second limit view instead, which never touches the count or the interrupt. A limit of zero turns a timer into a plain free-running counter with no interrupt. A configuration word can switch any per-processor timer into a user counter. That counter is gated by its own start bit, wraps modulo 2^32 and never interrupts. The system timer's count can be read at any time as a time base without side effects.

Top module: `limit_timer_unit`

## Requirements
- R1: Address map, with N = `NCPU`. Per-processor timer i sits at word 4i+0 (limit, read acknowledges), 4i+1 (count), 4i+2 (limit without acknowledge) and 4i+3 (start, bit 0). The system timer sits at 4N+0, 4N+1 and 4N+2. The configuration word is at 4N+4, where bit i selects user-counter mode for processor timer i. Every other address reads 0 and ignores writes. After reset, every register is 0 and every interrupt output is low.
- R2: In limit mode with a nonzero limit, a `tick` cycle increments the count by 1. If the count already equals the limit, the tick instead reloads the count to 1 and raises the timer's interrupt. The system timer drives `irqSys` (processor level 10), and processor timer i drives `irqCpu[i]` (level 14).
- R3: A raised interrupt stays high across further wraps until it is acknowledged.
- R4: A bus read of a timer's limit word returns the limit and clears that timer's interrupt in the next cycle. If a wrap happens in the same cycle as the read, the interrupt stays high.
- R5: Bus reads of the count word or of the no-acknowledge limit word leave the interrupt unchanged.
- R6: A write to the limit word stores the limit, sets the count to 1 and clears the interrupt.
- R7: A write to the no-acknowledge limit word stores the limit and leaves both the count and the interrupt unchanged.
- R8: With a limit of 0, a timer in limit mode counts every tick, wraps modulo 2^32 and never raises its interrupt.
- R9: A processor timer whose configuration bit is 1 counts a tick only while its start bit is 1, wraps modulo 2^32 regardless of its limit, and holds its interrupt low. Setting the bit clears a pending interrupt in the cycle after the write. Writing all zeros to the configuration word returns every processor timer to limit mode.
- R10: A write to a count word loads it, and the write takes precedence over a `tick` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for all timers, one step per high cycle |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (carries the acknowledge side effect) |
| regAddr | input | ADDR_W | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from `regAddr` |
| irqSys | output | 1 | System timer interrupt (level 10) |
| irqCpu | output | NCPU | Per-processor timer interrupts (level 14) |

## Verification
The bench looks for several specific faults. It lines a limit read up with a wrap in the same cycle: a design that favoured the acknowledge would lose that event and show the interrupt low. It reads the count and the no-acknowledge alias while an interrupt is pending: a decoder that lets those reads acknowledge would drop the line early. It rewrites the limit through both views: swapping the two write paths would either reset a running count or leave a stale interrupt. It also drives counts across 2^32 with a zero limit and in user mode, runs a stopped user counter, and uses a count write in the same cycle as a tick. These catch a missing wrap, a spurious interrupt, a start gate that is ignored, or a tick that overrides the write.

// File: rtl/ltu_pkg.sv
package ltu_pkg;
  // per-timer strobes produced by the decoder
  typedef struct packed {
    logic wrLimit;
    logic wrNoAck;
    logic wrCount;
    logic wrStart;
    logic rdAck;
  } strobe_t;

  typedef enum logic [1:0] {
    F_LIMIT = 2'd0,
    F_COUNT = 2'd1,
    F_NOACK = 2'd2,
    F_START = 2'd3
  } field_e;
endpackage

// File: rtl/ltu_ctl.sv
module ltu_ctl #(
  parameter int NCPU   = 2,
  parameter int ADDR_W = 6
) (
  input  logic                   regWr,
  input  logic                   regRd,
  input  logic [ADDR_W-1:0]      regAddr,
  output ltu_pkg::strobe_t [NCPU:0] strb,
  output logic                   cfgWr,
  output logic                   rdTimer,
  output logic                   rdCfg,
  output logic [ADDR_W-3:0]      rdIdx,
  output logic [1:0]             rdField
);
  import ltu_pkg::*;
  localparam int NT    = NCPU + 1;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       fld;
  logic             tHit;

  assign idx = regAddr[ADDR_W-1:2];
  assign fld = regAddr[1:0];

  // global timer has no start word
  assign tHit = (int'(idx) < NCPU) ||
                ((int'(idx) == NCPU) && (fld != F_START));

  assign cfgWr   = regWr && (int'(idx) == NCPU + 1) && (fld == 2'd0);
  assign rdCfg   = (int'(idx) == NCPU + 1) && (fld == 2'd0);
  assign rdTimer = tHit;
  assign rdIdx   = idx;
  assign rdField = fld;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      strb[t] = '0;
      if (tHit && int'(idx) == t) begin
        strb[t].wrLimit = regWr && (fld == F_LIMIT);
        strb[t].wrCount = regWr && (fld == F_COUNT);
        strb[t].wrNoAck = regWr && (fld == F_NOACK);
        strb[t].wrStart = regWr && (fld == F_START);
        strb[t].rdAck   = regRd && (fld == F_LIMIT);
      end
    end
  end
endmodule

// File: rtl/ltu_dp.sv
module ltu_dp #(
  parameter int NCPU   = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tick,
  input  logic [CNT_W-1:0]          wdata,
  input  ltu_pkg::strobe_t [NCPU:0] strb,
  input  logic                      cfgWr,
  input  logic                      rdTimer,
  input  logic                      rdCfg,
  input  logic [ADDR_W-3:0]         rdIdx,
  input  logic [1:0]                rdField,
  output logic [CNT_W-1:0]          rdata,
  output logic [NCPU:0]             flags
);
  import ltu_pkg::*;
  localparam int NT = NCPU + 1;

  logic [NCPU-1:0]  cfgReg;
  logic [NCPU-1:0]  cfgNext;
  logic [CNT_W-1:0] cntA   [NT];
  logic [CNT_W-1:0] limA   [NT];
  logic             startA [NT];

  assign cfgNext = cfgWr ? wdata[NCPU-1:0] : cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else       cfgReg <= cfgNext;
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic userMode, userNext, run, hit;
    logic [CNT_W-1:0] cnt, lim;
    logic flag, startB;

    if (t < NCPU) begin : g_cpu
      assign userMode = cfgReg[t];
      assign userNext = cfgNext[t];
    end else begin : g_sys
      assign userMode = 1'b0;
      assign userNext = 1'b0;
    end

    assign run = userMode ? startB : 1'b1;
    assign hit = !userMode && (lim != '0) && (cnt == lim);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt    <= '0;
        lim    <= '0;
        flag   <= 1'b0;
        startB <= 1'b0;
      end else begin
        if (strb[t].wrStart) startB <= wdata[0];
        if (strb[t].wrLimit || strb[t].wrNoAck) lim <= wdata;
        if (strb[t].wrLimit)       cnt <= CNT_W'(1);
        else if (strb[t].wrCount)  cnt <= wdata;
        else if (tick && run)      cnt <= hit ? CNT_W'(1) : cnt + CNT_W'(1);
        if (userNext || strb[t].wrLimit) flag <= 1'b0;
        else if (tick && hit)            flag <= 1'b1;
        else if (strb[t].rdAck)          flag <= 1'b0;
      end
    end

    assign cntA[t]   = cnt;
    assign limA[t]   = lim;
    assign startA[t] = startB;
    assign flags[t]  = flag;
  end

  always_comb begin
    rdata = '0;
    if (rdCfg) begin
      rdata[NCPU-1:0] = cfgReg;
    end else if (rdTimer) begin
      for (int t = 0; t < NT; t++) begin
        if (int'(rdIdx) == t) begin
          case (rdField)
            F_LIMIT, F_NOACK: rdata = limA[t];
            F_COUNT:          rdata = cntA[t];
            default:          rdata = {{(CNT_W-1){1'b0}}, startA[t]};
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/limit_timer_unit.sv
module limit_timer_unit #(
  parameter int NCPU   = 2,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqSys,
  output logic [NCPU-1:0]   irqCpu
);
  import ltu_pkg::*;

  strobe_t [NCPU:0] strb;
  logic cfgWr, rdTimer, rdCfg;
  logic [ADDR_W-3:0] rdIdx;
  logic [1:0] rdField;
  logic [NCPU:0] flags;

  ltu_ctl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) ctl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .strb(strb),
    .cfgWr(cfgWr), .rdTimer(rdTimer), .rdCfg(rdCfg),
    .rdIdx(rdIdx), .rdField(rdField)
  );

  ltu_dp #(.NCPU(NCPU), .CNT_W(32), .ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wdata(regWdata), .strb(strb),
    .cfgWr(cfgWr), .rdTimer(rdTimer), .rdCfg(rdCfg), .rdIdx(rdIdx),
    .rdField(rdField), .rdata(regRdata), .flags(flags)
  );

  assign irqSys = flags[NCPU];
  assign irqCpu = flags[NCPU-1:0];
endmodule

// File: rtl/ltu_chk.sv
module ltu_chk #(
  parameter int NCPU   = 2,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              regWr,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr,
  input logic              irqSys,
  input logic [NCPU-1:0]   irqCpu
);
  localparam logic [ADDR_W-1:0] SYS_LIM = ADDR_W'(4 * NCPU);

  // R6
  sys_limit_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == SYS_LIM) |=> !irqSys);

  // R2
  sys_raise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqSys) |-> $past(tick));

  // R2
  cpu_raise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(irqCpu & ~$past(irqCpu)) != 0) |-> $past(tick));

  // R3
  sys_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqSys) |-> $past(regRd || regWr));

  // R3
  cpu_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones($past(irqCpu) & ~irqCpu) != 0) |-> $past(regRd || regWr));
endmodule

bind limit_timer_unit ltu_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .tick(tick), .regWr(regWr), .regRd(regRd),
  .regAddr(regAddr), .irqSys(irqSys), .irqCpu(irqCpu)
);

// File: tb/limit_timer_unit_test.sv
module limit_timer_unit_test;
  localparam int NCPU = 2;
  localparam int AW   = 6;
  localparam logic [AW-1:0] C0_LIM = 6'd0, C0_CNT = 6'd1, C0_START = 6'd3;
  localparam logic [AW-1:0] C1_LIM = 6'd4, C1_CNT = 6'd5;
  localparam logic [AW-1:0] S_LIM = 6'd8, S_CNT = 6'd9, S_NOACK = 6'd10;
  localparam logic [AW-1:0] CFG = 6'd12, HOLE = 6'd13;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic irqSys;
  logic [NCPU-1:0] irqCpu;
  int total = 0, bad = 0;
  bit done = 0;

  limit_timer_unit #(.NCPU(NCPU), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqSys(irqSys), .irqCpu(irqCpu)
  );

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic peek(logic [AW-1:0] a, output logic [31:0] d);
    regAddr = a; #1 d = regRdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    @(negedge clk);
    check("R1 reset irqSys", 32'(irqSys), 0);
    check("R1 reset irqCpu", 32'(irqCpu), 0);
    peek(S_LIM, v); check("R1 reset sys limit", v, 0);
    peek(CFG, v);   check("R1 reset cfg", v, 0);
    wr(HOLE, 32'h1234);
    peek(HOLE, v);  check("R1 hole reads 0", v, 0);
  endtask

  task automatic test_wrap();
    logic [31:0] v;
    wr(S_LIM, 3);
    peek(S_CNT, v); check("R6 count=1 after limit write", v, 1);
    ticks(2);
    peek(S_CNT, v); check("R2 count before wrap", v, 3);
    check("R2 no irq before wrap", 32'(irqSys), 0);
    ticks(1);
    peek(S_CNT, v); check("R2 count reload", v, 1);
    check("R2 irq raised", 32'(irqSys), 1);
    ticks(3);
    check("R3 irq held over second wrap", 32'(irqSys), 1);
    rd(S_CNT, v);
    check("R5 count read keeps irq", 32'(irqSys), 1);
    rd(S_NOACK, v);
    check("R5 noack read keeps irq", 32'(irqSys), 1);
    rd(S_LIM, v);
    check("R4 limit read value", v, 3);
    check("R4 limit read clears irq", 32'(irqSys), 0);
  endtask

  task automatic test_ack_race();
    logic [31:0] v;
    ticks(2);
    peek(S_CNT, v); check("R4 setup count", v, 3);
    @(negedge clk); tick = 1'b1; regRd = 1'b1; regAddr = S_LIM;
    @(negedge clk); tick = 1'b0; regRd = 1'b0;
    check("R4 wrap beats ack", 32'(irqSys), 1);
    wr(S_LIM, 5);
    check("R6 limit write clears irq", 32'(irqSys), 0);
    peek(S_CNT, v); check("R6 count reset", v, 1);
  endtask

  task automatic test_noack();
    logic [31:0] v;
    ticks(2);
    wr(S_NOACK, 10);
    peek(S_CNT, v); check("R7 count kept", v, 3);
    peek(S_LIM, v); check("R7 limit updated", v, 10);
    ticks(8);
    check("R7 wrap at new limit", 32'(irqSys), 1);
    wr(S_NOACK, 4);
    check("R7 irq kept", 32'(irqSys), 1);
    peek(S_CNT, v); check("R7 count kept again", v, 1);
    rd(S_LIM, v);
  endtask

  task automatic test_zero_limit();
    logic [31:0] v;
    wr(C0_CNT, 32'hFFFF_FFFE);
    ticks(3);
    peek(C0_CNT, v); check("R8 wrap mod 2^32", v, 1);
    check("R8 no irq", 32'(irqCpu[0]), 0);
    @(negedge clk); tick = 1'b1; regWr = 1'b1; regAddr = S_CNT; regWdata = 100;
    @(negedge clk); tick = 1'b0; regWr = 1'b0;
    peek(S_CNT, v); check("R10 count write beats tick", v, 100);
  endtask

  task automatic test_user();
    logic [31:0] v;
    wr(C0_LIM, 2);
    wr(CFG, 1);
    peek(CFG, v); check("R9 cfg readback", v, 1);
    ticks(3);
    peek(C0_CNT, v); check("R9 stopped counter holds", v, 1);
    wr(C0_START, 1);
    peek(C0_START, v); check("R9 start readback", v, 1);
    ticks(3);
    peek(C0_CNT, v); check("R9 runs past limit", v, 4);
    check("R9 no irq in user mode", 32'(irqCpu[0]), 0);
    wr(C0_CNT, 32'hFFFF_FFFF);
    ticks(1);
    peek(C0_CNT, v); check("R9 wrap mod 2^32", v, 0);
    wr(C1_LIM, 2);
    ticks(2);
    check("R2 cpu1 irq in limit mode", 32'(irqCpu[1]), 1);
    wr(CFG, 2);
    check("R9 user mode clears irq", 32'(irqCpu[1]), 0);
    wr(CFG, 0);
    wr(C1_LIM, 2);
    ticks(2);
    check("R9 cfg zero restores limit mode", 32'(irqCpu[1]), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    test_reset();
    test_wrap();
    test_ack_race();
    test_noack();
    test_zero_limit();
    test_user();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule